// File: doc/BRIEF.md
# Programmable 16-bit Interval Timer

This block is a single 16-bit up-counter that software controls through three small registers: the live count, a compare target and a mode word. On each tick the count advances by one. The tick comes from one of three places: every system clock, every eighth system clock, or each rising edge of an external pulse input after that input has been synchronised. The block compares the count with the target and watches for wrap-around past 0xFFFF. It records each event in sticky flag bits of the mode word and can raise a single-cycle interrupt request.

The mode word sets the counting behaviour. One bit makes the counter restart from zero at the target. Two bits enable the interrupt for target and wrap events, and one bit chooses between a one-shot interrupt and a repeating one. Writing the mode word restarts the count and re-arms the one-shot latch. Reading the mode word returns its value and then clears the two event flags. Software reads the count at any time and can reload it directly. It can also change the target while the counter runs.

Top module: `tmr16_timer`

## Requirements
- R1: After reset the mode word reads 0x0000, the target reads 0x0000 and `irq` is low. Register address 3 always reads zero.
- R2: The count is at address 0. With the stop bit (bit 0), the external tick bit (bit 8) and the divide bit (bit 9) all clear, the count goes up by one on every clock. It wraps from 0xFFFF to 0x0000 unless bit 3 stops it earlier. A count write loads the written value on that edge, and counting continues from it.
- R3: When mode bit 3 is set, a tick that would bring the count to the target value loads zero instead. The count then runs 0 to target-1, so it repeats every target ticks.
- R4: With mode bit 4 set, `irq` goes high for exactly one cycle. It rises on the same clock edge as the tick that makes the count reach the target.
- R5: With mode bit 5 set, `irq` goes high for one cycle. It rises on the clock edge where the count wraps from 0xFFFF to 0x0000.
- R6: With mode bit 6 clear, only the first enabled event after a mode write raises `irq`. With bit 6 set, every enabled event raises it. Every mode write re-arms the one-shot latch.
- R7: A target event sets mode bit 11 and a wrap event sets mode bit 12. Either event also sets bit 10.
- R8: The mode word is at address 1. A read returns the current value, and on that clock edge bits 11 and 12 are cleared while every other bit is kept. An event in the same cycle still sets its flag.
- R9: A mode write sets the count to zero. Bits 0 to 9 take the written value. Bits 10 to 12 are cleared, and bits 13 to 15 always read zero.
- R10: With mode bit 9 set and bit 8 clear, the count goes up once every eight clocks. The first such tick comes on the eighth clock edge after the mode write.
- R11: With mode bit 0 set, the count does not change.
- R12: With mode bit 8 set, the count goes up once for each rising edge of `ext_tick`, however long the input stays high. The increment lands on the third clock edge after the input rises.
- R13: The target is at address 2. A target write changes only the target: the count keeps the value and progression it would have had without the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 count, 1 mode, 2 target, 3 unused |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; a mode read clears the event flags |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| ext_tick | input | 1 | Asynchronous external tick pulse |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The count is checked in free-running, clear-at-target, divide-by-eight, stopped and external-edge modes. Each mode produces a distinct count sequence for the same number of clock edges, so a wrong tick source or wrap rule shows up as a wrong count. Directed cases set the count just below 0xFFFF to isolate the wrap event, and use small targets to compare one-shot with repeating interrupt counts over several periods. Back-to-back mode reads separate the cleared flags from the kept bit 10. Randomised targets, clear-at-target and divide settings, and wait lengths then compare the read-back count with a closed-form expectation computed from the elapsed clock edges.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_TARGET = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Mode word; bit positions are software visible.
    typedef struct packed {
        logic [2:0] zero_hi;     // 15:13 always zero
        logic       wrapped;     // 12 wrap seen (read clears)
        logic       tgt_hit;     // 11 target seen (read clears)
        logic       evt_seen;    // 10 any event seen
        logic       div8;        // 9 tick every eighth clock
        logic       ext_sel;     // 8 external tick source
        logic       spare7;      // 7 plain storage
        logic       rpt_irq;     // 6 repeating interrupt
        logic       irq_wrap;    // 5 interrupt on wrap
        logic       irq_tgt;     // 4 interrupt on target
        logic       clr_at_tgt;  // 3 restart at target
        logic [1:0] spare21;     // 2:1 plain storage
        logic       stop;        // 0 halt counting
    } mode_t;

    typedef struct packed {
        logic at_tgt;
        logic at_wrap;
    } evt_t;

    function automatic mode_t mode_from_bus(input logic [REG_W-1:0] d);
        mode_t m;
        m          = mode_t'(d);
        m.wrapped  = 1'b0;
        m.tgt_hit  = 1'b0;
        m.evt_seen = 1'b0;
        m.zero_hi  = '0;
        return m;
    endfunction

    function automatic mode_t mode_after_read(input mode_t m);
        mode_t r;
        r         = m;
        r.tgt_hit = 1'b0;
        r.wrapped = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/tmr16_tick_gen.sv
`timescale 1ns/1ps
module tmr16_tick_gen #(
    parameter int DIV_LOG2    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic stop,
    input  logic ext_sel,
    input  logic div8,
    input  logic ext_in,
    output logic tick
);

    logic [DIV_LOG2-1:0]  pre_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_edge;
    logic                 int_tick;

    always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
    end

    assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_comb begin
        int_tick = div8 ? (pre_q == '1) : 1'b1;
        tick     = ~stop & (ext_sel ? ext_edge : int_tick);
    end

    AST_DIV8_SPACED: assert property (@(posedge clk) disable iff (rst)
        (div8 && !ext_sel && tick && !restart) |=> !tick); // R10

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && tick && !restart) |=> !tick); // R12

endmodule

// File: rtl/tmr16_count_core.sv
`timescale 1ns/1ps
module tmr16_count_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tgt_wr,
    input  logic [CNT_W-1:0] tgt_val,
    input  logic             clr_at_tgt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] tgt_q,
    output evt_t             evt
);

    logic [CNT_W-1:0] cnt_inc;
    logic             adv;
    logic             reach;
    logic             top;

    always_comb begin
        cnt_inc     = cnt_q + 1'b1;
        adv         = tick & ~load & ~restart;
        reach       = (cnt_inc == tgt_q);
        top         = (cnt_q == '1);
        evt.at_tgt  = adv & reach;
        evt.at_wrap = adv & top;
    end

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= '0;
        else if (restart)              cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (adv && reach && clr_at_tgt) cnt_q <= '0;
        else if (adv)                  cnt_q <= cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (rst)         tgt_q <= '0;
        else if (tgt_wr) tgt_q <= tgt_val;
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !restart) |=> $stable(cnt_q)); // R11

    AST_TGT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (evt.at_tgt && clr_at_tgt) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/tmr16_mode_regs.sv
`timescale 1ns/1ps
module tmr16_mode_regs
    import tmr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  logic             mode_rd,
    input  logic [REG_W-1:0] wdata,
    input  evt_t             evt,
    output mode_t            mode_q,
    output logic             irq_q
);

    mode_t mode_nxt;
    logic  armed_q;
    logic  want;
    logic  fire;

    always_comb begin
        mode_nxt = mode_rd ? mode_after_read(mode_q) : mode_q;
        if (evt.at_tgt) begin
            mode_nxt.tgt_hit  = 1'b1;
            mode_nxt.evt_seen = 1'b1;
        end
        if (evt.at_wrap) begin
            mode_nxt.wrapped  = 1'b1;
            mode_nxt.evt_seen = 1'b1;
        end
        want = (evt.at_tgt & mode_q.irq_tgt) | (evt.at_wrap & mode_q.irq_wrap);
        fire = want & (mode_q.rpt_irq | armed_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            armed_q <= 1'b1;
            irq_q   <= 1'b0;
        end else if (mode_wr) begin
            mode_q  <= mode_from_bus(wdata);
            armed_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            mode_q <= mode_nxt;
            irq_q  <= fire;
            if (fire) armed_q <= 1'b0;
        end
    end

    AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
        mode_q.zero_hi == 3'b000); // R9

    AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ((mode_q.tgt_hit || mode_q.wrapped) && mode_q.evt_seen)); // R7

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !mode_q.rpt_irq && !mode_wr) |=> !irq_q); // R6

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode_rd && !mode_wr && !evt.at_tgt) |=> !mode_q.tgt_hit); // R8

endmodule

// File: rtl/tmr16_timer.sv
`timescale 1ns/1ps
module tmr16_timer
    import tmr16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_LOG2    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ext_tick,
    output logic              irq
);

    reg_sel_e         sel;
    logic             wr_cnt, wr_mode, wr_tgt, rd_mode;
    logic             tick;
    mode_t            mode_q;
    evt_t             evt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;

    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        wr_cnt  = reg_wr & (sel == SEL_COUNT);
        wr_mode = reg_wr & (sel == SEL_MODE);
        wr_tgt  = reg_wr & (sel == SEL_TARGET);
        rd_mode = reg_rd & (sel == SEL_MODE);
    end

    tmr16_tick_gen #(
        .DIV_LOG2   (DIV_LOG2),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .restart(wr_mode),
        .stop   (mode_q.stop),
        .ext_sel(mode_q.ext_sel),
        .div8   (mode_q.div8),
        .ext_in (ext_tick),
        .tick   (tick)
    );

    tmr16_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .restart   (wr_mode),
        .load      (wr_cnt),
        .load_val  (reg_wdata[CNT_W-1:0]),
        .tgt_wr    (wr_tgt),
        .tgt_val   (reg_wdata[CNT_W-1:0]),
        .clr_at_tgt(mode_q.clr_at_tgt),
        .cnt_q     (cnt_q),
        .tgt_q     (tgt_q),
        .evt       (evt)
    );

    tmr16_mode_regs u_mode (
        .clk    (clk),
        .rst    (rst),
        .mode_wr(wr_mode),
        .mode_rd(rd_mode),
        .wdata  (reg_wdata),
        .evt    (evt),
        .mode_q (mode_q),
        .irq_q  (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_COUNT:  reg_rdata = REG_W'(cnt_q);
            SEL_MODE:   reg_rdata = mode_q;
            SEL_TARGET: reg_rdata = REG_W'(tgt_q);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/tmr16_timer_test.sv
`timescale 1ns/1ps
module tmr16_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;

    int unsigned total = 0;
    int unsigned bad = 0;
    int unsigned ecount = 0;
    int unsigned last_edge = 0;
    int unsigned irq_n = 0;
    int unsigned irq_edge = 0;
    bit          done = 0;

    tmr16_timer uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) ecount <= ecount + 1;

    always @(negedge clk) begin
        if (!rst && irq) begin
            irq_n    = irq_n + 1;
            irq_edge = ecount;
        end
    end

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        last_edge = ecount;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d, output int unsigned at);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        d  = reg_rdata;
        at = ecount;
        @(posedge clk);
        #1;
        reg_rd = 1'b0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int unsigned exp_cnt(input int unsigned k, input bit clr,
                                            input int unsigned t, input bit d8);
        int unsigned ticks;
        ticks = d8 ? (k / 8) : k;
        if (clr && t != 0) return ticks % t;
        return ticks % 65536;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int unsigned at, me, n0, t;
        bit c, dv;
        void'($urandom(32'd1234));

        waitc(3);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", irq, 0);
        rd(2'd1, v, at); chk("R1 mode reset", v, 16'h0000);
        rd(2'd2, v, at); chk("R1 target reset", v, 16'h0000);
        rd(2'd3, v, at); chk("R1 unused address", v, 16'h0000);

        // R2 free running and R9 restart
        wr(2'd1, 16'h0000); me = last_edge;
        waitc(37);
        rd(2'd0, v, at); chk("R2 free count", v, exp_cnt(at - me, 0, 0, 0));
        wr(2'd0, 16'hFFFD); me = last_edge;
        waitc(4);
        rd(2'd0, v, at); chk("R2 load and wrap", v, (32'hFFFD + (at - me)) % 65536);

        // R13 target write keeps count
        wr(2'd1, 16'h0000); me = last_edge;
        waitc(10);
        wr(2'd2, 16'h0123);
        waitc(5);
        rd(2'd0, v, at); chk("R13 count undisturbed", v, exp_cnt(at - me, 0, 0, 0));
        rd(2'd2, v, at); chk("R13 target readback", v, 16'h0123);

        // R3 clear at target
        wr(2'd2, 16'd7);
        wr(2'd1, 16'h0008); me = last_edge;
        waitc(30);
        rd(2'd0, v, at); chk("R3 clear at target", v, exp_cnt(at - me, 1, 7, 0));

        // R4 target irq timing, R7 flags, R8 read clear
        wr(2'd2, 16'd20);
        n0 = irq_n;
        wr(2'd1, 16'h0010); me = last_edge;
        waitc(30);
        chk("R4 one target irq", irq_n - n0, 1);
        chk("R4 irq edge", irq_edge - me, 20);
        rd(2'd1, v, at); chk("R7 flags after target", v, 16'h0C10);
        rd(2'd1, v, at); chk("R8 read clears 11 and 12", v, 16'h0410);

        // R6 one-shot versus repeat, re-arm
        wr(2'd2, 16'd10);
        n0 = irq_n;
        wr(2'd1, 16'h0018);
        waitc(44);
        chk("R6 one-shot count", irq_n - n0, 1);
        n0 = irq_n;
        wr(2'd1, 16'h0058);
        waitc(44);
        chk("R6 repeat count", irq_n - n0, 4);
        n0 = irq_n;
        wr(2'd1, 16'h0018);
        waitc(14);
        chk("R6 mode write re-arms", irq_n - n0, 1);

        // R5 wrap irq, R7 wrap flag
        wr(2'd2, 16'h8000);
        wr(2'd1, 16'h0020);
        n0 = irq_n;
        wr(2'd0, 16'hFFF0); me = last_edge;
        waitc(20);
        chk("R5 one wrap irq", irq_n - n0, 1);
        chk("R5 irq on wrap edge", irq_edge - me, 16);
        rd(2'd1, v, at); chk("R7 flags after wrap", v, 16'h1420);

        // R9 mode write masking, R11 stop
        wr(2'd1, 16'hFFFF);
        rd(2'd1, v, at); chk("R9 mode write masks 10-15", v, 16'h03FF);
        wr(2'd1, 16'h0001);
        waitc(20);
        rd(2'd0, v, at); chk("R11 stopped count", v, 0);

        // R10 divide by eight
        wr(2'd1, 16'h0200); me = last_edge;
        waitc(50);
        rd(2'd0, v, at); chk("R10 divided count", v, exp_cnt(at - me, 0, 0, 1));

        // R12 external tick edges
        wr(2'd1, 16'h0100);
        for (int i = 0; i < 5; i++) begin
            ext_tick = 1'b1; waitc(5);
            ext_tick = 1'b0; waitc(3);
        end
        waitc(4);
        rd(2'd0, v, at); chk("R12 external edges", v, 5);

        // Random: R2 R3 R10 across modes
        for (int it = 0; it < 24; it++) begin
            t  = 2 + ($urandom % 60);
            c  = $urandom % 2;
            dv = $urandom % 2;
            wr(2'd2, 16'(t));
            wr(2'd1, 16'((c ? 16'h0008 : 16'h0) | (dv ? 16'h0200 : 16'h0))); me = last_edge;
            waitc($urandom % 300);
            rd(2'd0, v, at);
            chk(c ? "R3 random count" : (dv ? "R10 random count" : "R2 random count"),
                v, exp_cnt(at - me, c, t, dv));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule